// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in byte-addressed memory and sends each frame that the host has handed over. A pulse on `reg_touch` marks that the host has touched the register port. Unless the stop control is high, the pulse starts one scan of the ring. The scan begins at a saved transmit pointer and steps forward modulo the ring size. It ends before the index just behind the pointer where it started, so a single trigger can send several frames.

For each descriptor that is ready, the engine reads a length word. The word is stored with its bytes swapped and holds the count as a negative two's-complement value. The engine converts it to a byte count and caps that count at the packet buffer size. It then streams the buffer out on a byte valid/ready port, with a last marker on the final byte. After the last byte is accepted, it writes the descriptor status back to "done", advances the transmit pointer by one and sets the transmit and summary interrupt flags. When a scan ends, it raises the interrupt line if the summary flag is set and interrupts are enabled.

The ring base address is the sum of an initialization pointer and a DMA offset. The memory behind it returns read data one cycle after the request.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the stream output is idle, `busy`, `tint`, `intr` and `irq` are low, and the saved transmit pointer is 0.
- R2: A `reg_touch` pulse while `stop` is high starts no scan. No memory access is made, no byte is sent and descriptor state is unchanged.
- R3: A descriptor is sent only if its status byte equals 8'h81 exactly (owner bit 7 plus packet-OK bit 0). Any other value, such as 8'h80 or 8'h83, is skipped and left untouched.
- R4: Descriptor i occupies 4 bytes at base+4*i. Byte +0 holds the high byte of the length word, byte +1 the low byte and byte +2 the status. The byte count equals 65536 minus the length word. The frame data of descriptor i starts at base+4*RING+i*PKT_BYTES.
- R5: A byte count above PKT_BYTES (64 by default), including the one from a length word of 0, is clipped to PKT_BYTES.
- R6: Frame bytes leave in address order on `tx_data`, each transferred when `tx_valid` and `tx_ready` are both high. `tx_last` is high only on the final byte. Data and marker hold steady while a byte is stalled.
- R7: Once the final byte is accepted, the status byte of that descriptor is rewritten to 8'h01.
- R8: A scan examines indices from the saved pointer upward, wrapping modulo RING. It stops before the index one behind its start, and that index is never examined.
- R9: The saved pointer advances by exactly one for each frame sent, whatever index the frame came from.
- R10: Every sent frame sets `tint` and `intr`. A pulse on `irq_ack` clears `tint`, `intr` and `irq`.
- R11: At the end of each scan, `irq` rises if `intr` is set and `int_en` is high. `irq` never rises otherwise.
- R12: A `reg_touch` during a scan causes one more scan after the current one. That scan starts from the updated pointer, provided `stop` is low.
- R13: The ring base address is `ring_base + dma_offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_touch | input | 1 | Host register access pulse; requests a scan |
| stop | input | 1 | Stop control; blocks new scans while high |
| int_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears tint, intr and irq |
| ring_base | input | ADDR_W | Initialization pointer |
| dma_offset | input | ADDR_W | DMA offset added to the pointer |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the request |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Frame sink ready |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| tint | output | 1 | Transmit interrupt flag |
| intr | output | 1 | Summary interrupt flag |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | Scan in progress |

## Verification
The hardest case to reach is a trigger that lands while a scan is under way and makes ready a descriptor the scan has already passed. The bench handles this by readying two descriptors, a short one and then a long one. While the second frame is still streaming, it re-arms the first descriptor and pulses `reg_touch`. Only a follow-up scan from the advanced pointer can send that frame again.

The pointer rule (one step per frame, not a jump to the sent index) is also hidden from the ports. The bench exposes it by readying only the descriptor one behind the expected pointer after a scan that skipped a descriptor. A wrong pointer would bring that index inside the next scan's window.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

   localparam logic [7:0] DESC_OWNER = 8'h80;
   localparam logic [7:0] DESC_OK    = 8'h01;
   localparam logic [7:0] DESC_READY = DESC_OWNER | DESC_OK;
   localparam logic [7:0] DESC_DONE  = DESC_OK;

   localparam int DESC_BYTES = 4;
   localparam int OFF_LEN_HI = 0;
   localparam int OFF_LEN_LO = 1;
   localparam int OFF_STAT   = 2;

   typedef enum logic [1:0] {
      SEL_LEN_HI,
      SEL_LEN_LO,
      SEL_STAT,
      SEL_BUF
   } addr_sel_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STAT_REQ,
      ST_STAT_CHK,
      ST_LEN_A,
      ST_LEN_B,
      ST_BYTE_REQ,
      ST_BYTE_GET,
      ST_BYTE_OUT,
      ST_WB,
      ST_NEXT
   } scan_state_e;

endpackage

// File: rtl/txr_addr_gen.sv
module txr_addr_gen
   import tx_ring_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int RING      = 16,
   parameter int PKT_BYTES = 64,
   localparam int IDX_W    = $clog2(RING),
   localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [ADDR_W-1:0] dma_offset,
   input  logic [IDX_W-1:0]  idx,
   input  logic [CNT_W-1:0]  byte_idx,
   input  addr_sel_e         sel,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] BUF_AREA = ADDR_W'(DESC_BYTES * RING);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] desc_base;
   logic [ADDR_W-1:0] buf_base;

   always_comb begin
      base      = ring_base + dma_offset;
      desc_base = base + (ADDR_W'(idx) * ADDR_W'(DESC_BYTES));
      buf_base  = base + BUF_AREA + (ADDR_W'(idx) * ADDR_W'(PKT_BYTES));
      unique case (sel)
         SEL_LEN_HI: addr = desc_base + ADDR_W'(OFF_LEN_HI);
         SEL_LEN_LO: addr = desc_base + ADDR_W'(OFF_LEN_LO);
         SEL_STAT:   addr = desc_base + ADDR_W'(OFF_STAT);
         default:    addr = buf_base + ADDR_W'(byte_idx);
      endcase
   end

endmodule

// File: rtl/txr_len_decode.sv
module txr_len_decode #(
   parameter int PKT_BYTES = 64,
   parameter bit SWAP_LEN  = 1'b1,
   localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
   input  logic [7:0]       first_byte,
   input  logic [7:0]       second_byte,
   output logic [CNT_W-1:0] count
);

   localparam logic [16:0] CAP = 17'(PKT_BYTES);

   logic [15:0] raw;
   logic [16:0] mag;

   generate
      if (SWAP_LEN) begin : g_swapped
         assign raw = {first_byte, second_byte};
      end else begin : g_native
         assign raw = {second_byte, first_byte};
      end
   endgenerate

   always_comb begin
      mag   = 17'h10000 - {1'b0, raw};
      count = (mag > CAP) ? CNT_W'(PKT_BYTES) : mag[CNT_W-1:0];
   end

endmodule

// File: rtl/txr_irq_ctl.sv
module txr_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done,
   input  logic scan_end,
   input  logic ack,
   input  logic int_en,
   output logic tint,
   output logic intr,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tint <= 1'b0;
         intr <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (frame_done) begin
            tint <= 1'b1;
            intr <= 1'b1;
         end else if (ack) begin
            tint <= 1'b0;
            intr <= 1'b0;
         end
         if (scan_end && intr && int_en)
            irq <= 1'b1;
         else if (ack)
            irq <= 1'b0;
      end
   end

   assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(int_en && intr && scan_end));

   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !frame_done && !scan_end) |=> (!tint && !intr && !irq));

endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
   import tx_ring_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int RING      = 16,
   parameter int PKT_BYTES = 64,
   parameter bit SWAP_LEN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_touch,
   input  logic              stop,
   input  logic              int_en,
   input  logic              irq_ack,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [ADDR_W-1:0] dma_offset,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              tint,
   output logic              intr,
   output logic              irq,
   output logic              busy
);

   localparam int IDX_W = $clog2(RING);
   localparam int CNT_W = $clog2(PKT_BYTES + 1);

   generate
      if (RING < 2 || (RING & (RING - 1)) != 0) begin : g_bad_ring
         $error("RING must be a power of two of at least 2");
      end
      if (PKT_BYTES < 1 || PKT_BYTES > 65535) begin : g_bad_pkt
         $error("PKT_BYTES must lie in 1..65535");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   scan_state_e      state;
   logic [IDX_W-1:0] txptr;
   logic [IDX_W-1:0] scan_idx;
   logic [IDX_W-1:0] end_idx;
   logic             pend;
   logic [7:0]       len_hi;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] byte_idx;
   logic [CNT_W-1:0] dec_count;
   addr_sel_e        sel;
   logic             desc_ready;
   logic             frame_done;
   logic             scan_end;
   logic             restart;
   logic [IDX_W-1:0] nxt_idx;

   txr_addr_gen #(
      .ADDR_W   (ADDR_W),
      .RING     (RING),
      .PKT_BYTES(PKT_BYTES)
   ) u_addr (
      .ring_base (ring_base),
      .dma_offset(dma_offset),
      .idx       (scan_idx),
      .byte_idx  (byte_idx),
      .sel       (sel),
      .addr      (mem_addr)
   );

   txr_len_decode #(
      .PKT_BYTES(PKT_BYTES),
      .SWAP_LEN (SWAP_LEN)
   ) u_len (
      .first_byte (len_hi),
      .second_byte(mem_rdata),
      .count      (dec_count)
   );

   txr_irq_ctl u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_done(frame_done),
      .scan_end  (scan_end),
      .ack       (irq_ack),
      .int_en    (int_en),
      .tint      (tint),
      .intr      (intr),
      .irq       (irq)
   );

   always_comb begin
      desc_ready = (mem_rdata == DESC_READY);
      nxt_idx    = scan_idx + 1'b1;
      frame_done = (state == ST_WB);
      scan_end   = (state == ST_NEXT) && (nxt_idx == end_idx);
      restart    = (pend || reg_touch) && !stop;
      busy       = (state != ST_IDLE);
      mem_wr_en  = (state == ST_WB);
      mem_wdata  = DESC_DONE;
      mem_rd_en  = 1'b0;
      sel        = SEL_STAT;
      unique case (state)
         ST_STAT_REQ: mem_rd_en = 1'b1;
         ST_STAT_CHK: begin
            mem_rd_en = desc_ready;
            sel       = SEL_LEN_HI;
         end
         ST_LEN_A: begin
            mem_rd_en = 1'b1;
            sel       = SEL_LEN_LO;
         end
         ST_BYTE_REQ: begin
            mem_rd_en = 1'b1;
            sel       = SEL_BUF;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         txptr    <= '0;
         scan_idx <= '0;
         end_idx  <= '0;
         pend     <= 1'b0;
         len_hi   <= '0;
         count    <= '0;
         byte_idx <= '0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
         tx_last  <= 1'b0;
      end else begin
         if (reg_touch && state != ST_IDLE)
            pend <= 1'b1;
         unique case (state)
            ST_IDLE: begin
               if (reg_touch && !stop) begin
                  scan_idx <= txptr;
                  end_idx  <= txptr - 1'b1;
                  state    <= ST_STAT_REQ;
               end
            end
            ST_STAT_REQ: state <= ST_STAT_CHK;
            ST_STAT_CHK: state <= desc_ready ? ST_LEN_A : ST_NEXT;
            ST_LEN_A: begin
               len_hi <= mem_rdata;
               state  <= ST_LEN_B;
            end
            ST_LEN_B: begin
               count    <= dec_count;
               byte_idx <= '0;
               state    <= ST_BYTE_REQ;
            end
            ST_BYTE_REQ: state <= ST_BYTE_GET;
            ST_BYTE_GET: begin
               tx_data  <= mem_rdata;
               tx_valid <= 1'b1;
               tx_last  <= (byte_idx == count - 1'b1);
               state    <= ST_BYTE_OUT;
            end
            ST_BYTE_OUT: begin
               if (tx_ready) begin
                  tx_valid <= 1'b0;
                  if (tx_last) begin
                     state <= ST_WB;
                  end else begin
                     byte_idx <= byte_idx + 1'b1;
                     state    <= ST_BYTE_REQ;
                  end
               end
            end
            ST_WB: begin
               txptr <= txptr + 1'b1;
               state <= ST_NEXT;
            end
            ST_NEXT: begin
               if (nxt_idx == end_idx) begin
                  pend <= 1'b0;
                  if (restart) begin
                     scan_idx <= txptr;
                     end_idx  <= txptr - 1'b1;
                     state    <= ST_STAT_REQ;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else begin
                  scan_idx <= nxt_idx;
                  state    <= ST_STAT_REQ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   assert_no_mem_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd_en && !mem_wr_en));

   assert_wb_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(tx_valid && tx_ready && tx_last));

   assert_ptr_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (txptr != $past(txptr)) |-> (txptr == $past(txptr) + 1'b1));

   assert_tint_from_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tint) |-> $past(mem_wr_en));

   assert_no_stream_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_valid);

endmodule

// File: tb/tx_ring_engine_test.sv
module tx_ring_engine_test;

   localparam int ADDR_W = 32;
   localparam int RING   = 16;
   localparam int PKT    = 64;
   localparam logic [31:0] INIT_PTR = 32'h100;
   localparam logic [31:0] DMA_OFF  = 32'h20;
   localparam int BASE   = 32'h120;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_touch = 1'b0;
   logic        stop = 1'b0;
   logic        int_en = 1'b1;
   logic        irq_ack = 1'b0;
   logic        mem_rd_en, mem_wr_en;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        tx_valid, tx_ready, tx_data_last_unused;
   logic [7:0]  tx_data;
   logic        tx_last, tint, intr, irq, busy;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tx_ring_engine #(.ADDR_W(ADDR_W), .RING(RING), .PKT_BYTES(PKT)) uut (
      .clk(clk), .rst_n(rst_n), .reg_touch(reg_touch), .stop(stop),
      .int_en(int_en), .irq_ack(irq_ack), .ring_base(INIT_PTR),
      .dma_offset(DMA_OFF), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .tint(tint), .intr(intr), .irq(irq), .busy(busy)
   );

   assign tx_data_last_unused = 1'b0;

   logic [7:0] mem [0:4095];
   int mem_access = 0;

   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
      if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_rd_en || mem_wr_en) mem_access <= mem_access + 1;
   end

   bit         bp_on = 0;
   logic [7:0] lfsr = 8'h5a;
   always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   assign tx_ready = bp_on ? lfsr[0] : 1'b1;

   logic [7:0] rx_data [0:2047];
   logic       rx_last [0:2047];
   int rx_n = 0;
   always @(posedge clk) begin
      if (tx_valid && tx_ready && rx_n < 2048) begin
         rx_data[rx_n] <= tx_data;
         rx_last[rx_n] <= tx_last;
         rx_n <= rx_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int desc(input int i);
      return BASE + 4 * i;
   endfunction

   function automatic int bufa(input int i);
      return BASE + 4 * RING + i * PKT;
   endfunction

   task automatic arm(input int i, input int cnt, input logic [7:0] tag);
      logic [15:0] v;
      v = 16'(32'h10000 - cnt);
      mem[desc(i)]     = v[15:8];
      mem[desc(i) + 1] = v[7:0];
      mem[desc(i) + 2] = 8'h81;
      for (int k = 0; k < PKT; k++) mem[bufa(i) + k] = tag + 8'(k);
   endtask

   task automatic touch();
      @(negedge clk) reg_touch = 1'b1;
      @(negedge clk) reg_touch = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk) irq_ack = 1'b1;
      @(negedge clk) irq_ack = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      repeat (2) @(negedge clk);
      while (busy && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic expect_frame(input int pos, input int len, input logic [7:0] tag,
                               input string req);
      int bad_d = 0;
      int bad_l = 0;
      for (int k = 0; k < len; k++) begin
         if (rx_data[pos + k] !== tag + 8'(k)) bad_d++;
         if (rx_last[pos + k] !== (k == len - 1)) bad_l++;
      end
      check(bad_d == 0, req, bad_d, 0);
      check(bad_l == 0, {req, " R6 last"}, bad_l, 0);
   endtask

   task automatic t_reset();
      check(!tx_valid && !busy, "R1 idle", {tx_valid, busy}, 0);
      check(!tint && !intr && !irq, "R1 flags", {tint, intr, irq}, 0);
   endtask

   task automatic t_single();
      int p = rx_n;
      arm(0, 5, 8'h10);
      touch();
      wait_idle();
      check(rx_n - p == 5, "R4 R13 count", rx_n - p, 5);
      expect_frame(p, 5, 8'h10, "R1 R4 data from index 0");
      check(mem[desc(0) + 2] == 8'h01, "R7 writeback", mem[desc(0) + 2], 1);
      check(tint && intr, "R10 flags set", {tint, intr}, 3);
      check(irq, "R11 irq raised", irq, 1);
      ack();
      check(!tint && !intr && !irq, "R10 ack clears", {tint, intr, irq}, 0);
   endtask

   task automatic t_stop();
      int p = rx_n;
      int a;
      arm(1, 4, 8'h20);
      stop = 1'b1;
      a = mem_access;
      touch();
      repeat (60) @(negedge clk);
      check(rx_n == p && mem_access == a, "R2 no scan", mem_access - a, 0);
      check(mem[desc(1) + 2] == 8'h81, "R2 status kept", mem[desc(1) + 2], 8'h81);
      stop = 1'b0;
      touch();
      wait_idle();
      check(rx_n - p == 4, "R2 after release", rx_n - p, 4);
      expect_frame(p, 4, 8'h20, "R4 data");
      ack();
   endtask

   task automatic t_exact();
      int p = rx_n;
      arm(2, 3, 8'h30);
      mem[desc(2) + 2] = 8'h80;
      arm(3, 3, 8'h38);
      mem[desc(3) + 2] = 8'h83;
      arm(4, 3, 8'h40);
      touch();
      wait_idle();
      check(rx_n - p == 3, "R3 one frame", rx_n - p, 3);
      expect_frame(p, 3, 8'h40, "R3 ready one sent");
      check(mem[desc(2) + 2] == 8'h80 && mem[desc(3) + 2] == 8'h83, "R3 skipped untouched",
            {mem[desc(2) + 2], mem[desc(3) + 2]}, 16'h8083);
      ack();
   endtask

   task automatic t_window();
      int p = rx_n;
      mem[desc(3) + 2] = 8'h00;
      arm(2, 3, 8'h48);
      touch();
      wait_idle();
      check(rx_n == p, "R8 R9 index behind pointer unseen", rx_n - p, 0);
      check(mem[desc(2) + 2] == 8'h81, "R9 status kept", mem[desc(2) + 2], 8'h81);
      mem[desc(2) + 2] = 8'h00;
   endtask

   task automatic t_multi();
      int p = rx_n;
      arm(15, 2, 8'h50);
      arm(0, 3, 8'h60);
      arm(1, 2, 8'h70);
      touch();
      wait_idle();
      check(rx_n - p == 7, "R8 three frames", rx_n - p, 7);
      expect_frame(p, 2, 8'h50, "R8 first idx15");
      expect_frame(p + 2, 3, 8'h60, "R8 wrap idx0");
      expect_frame(p + 5, 2, 8'h70, "R8 idx1");
      ack();
   endtask

   task automatic t_clip();
      int p = rx_n;
      arm(6, 100, 8'h80);
      arm(7, 5, 8'h90);
      mem[desc(7)] = 8'h00;
      mem[desc(7) + 1] = 8'h00;
      touch();
      wait_idle();
      check(rx_n - p == 2 * PKT, "R5 clipped sizes", rx_n - p, 2 * PKT);
      expect_frame(p, PKT, 8'h80, "R5 oversize");
      expect_frame(p + PKT, PKT, 8'h90, "R5 zero word");
      ack();
   endtask

   task automatic t_noirq();
      int p = rx_n;
      int_en = 1'b0;
      arm(8, 3, 8'hA0);
      touch();
      wait_idle();
      check(rx_n - p == 3, "R11 frame sent", rx_n - p, 3);
      check(tint && intr && !irq, "R11 masked", {tint, intr, irq}, 6);
      int_en = 1'b1;
      touch();
      wait_idle();
      check(irq, "R11 raised at next scan end", irq, 1);
      ack();
   endtask

   task automatic t_backpressure();
      int p = rx_n;
      arm(9, 9, 8'hB0);
      bp_on = 1;
      touch();
      wait_idle();
      bp_on = 0;
      check(rx_n - p == 9, "R6 count under stall", rx_n - p, 9);
      expect_frame(p, 9, 8'hB0, "R6 order under stall");
      ack();
   endtask

   task automatic t_pending();
      int p = rx_n;
      int n = 0;
      arm(10, 2, 8'hC0);
      arm(11, 20, 8'hD0);
      @(negedge clk) reg_touch = 1'b1;
      @(negedge clk) reg_touch = 1'b0;
      while (rx_n < p + 3 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      arm(10, 2, 8'hE0);
      @(negedge clk) reg_touch = 1'b1;
      @(negedge clk) reg_touch = 1'b0;
      wait_idle();
      check(rx_n - p == 24, "R12 three frames", rx_n - p, 24);
      expect_frame(p, 2, 8'hC0, "R12 first");
      expect_frame(p + 2, 20, 8'hD0, "R12 second");
      expect_frame(p + 22, 2, 8'hE0, "R12 rescan");
      ack();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #1_200_000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single();
      t_stop();
      t_exact();
      t_window();
      t_multi();
      t_clip();
      t_noirq();
      t_backpressure();
      t_pending();
      finish_run();
   end

endmodule